// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block brings four USB PHY instances up and down in hardware: a device port (ID 0), a host port (ID 1) and two HSIC ports (ID 2 and ID 3). It accepts one request at a time on a valid/ready port. Each request carries an instance ID, an on/off flag and the reference clock rate in MHz. The block then steps through a fixed sequence on the shared control vectors: clock select, power-down bits, reset bits, per-port isolation and the floating-prevention control. Microsecond waits come from a prescaler set by `CYC_PER_US`.

The request port follows the usual stream rules. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle. Back-pressure is absolute: while `req_ready` is low, the request fields are not sampled and they have no effect, whether or not `req_valid` is held. There is no queue, so an upstream source that wants its request served must hold `req_valid` until it sees `req_ready`. When a sequence completes, `done` pulses for one cycle. A power-on request with an unsupported rate pulses `err` instead.

Top module: `usb_phy_pwr_seq`

## Requirements
- R1: After reset, `pwr_down` is all ones (13 bits), `phy_rst` is zero, `iso_n` is zero (both ports isolated), `float_prev` is 0, `clk_sel` is 0, `req_ready` is 1, and `done` and `err` are 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the sequence ends. A request offered while `req_ready` is low changes no output.
- R3: On power-on, `clk_sel` takes the code for the requested rate after the 1st edge following acceptance: 48 MHz gives 0, 24 MHz gives 3, 12 MHz gives 2.
- R4: A power-on request with any other rate raises `err` for exactly the cycle after the acceptance edge. It changes no control output and produces no `done`. Power-off requests ignore the rate.
- R5: Power-down masks: device bits {0,3,4,5}, host {6,7,8}, HSIC0 {9,10}, HSIC1 {11,12}. Power-on clears the mask after the 2nd edge, and power-off sets it after the 2nd edge. All other bits keep their value.
- R6: Reset masks: device bit {0}, host {3,4,5,6,7}, HSIC0 {5,8}, HSIC1 {5,9}. Only the requested instance's mask is pulsed, and the other bits of `phy_rst` stay unchanged.
- R7: On power-on, the reset mask rises after the 3rd edge. It stays high for exactly 10*`CYC_PER_US` cycles, and no reset activity happens before power is applied.
- R8: `iso_n` bit 0 belongs to the device port and bit 1 to the host port, and 1 means not isolated. On power-on, the bit rises after edge 3+90*`CYC_PER_US`, which is 80 µs after reset release. A port's bit is never 1 while that port's power-down bits are set. HSIC requests leave `iso_n` untouched.
- R9: `float_prev` goes to 1 when the host powers on, in the same cycle its power bits clear. It goes to 0 when the host powers off, in the same cycle its power bits set. It is never 1 while the host is powered down.
- R10: Power-off order: the isolation bit clears after the 1st edge, then the power-down mask sets after the 2nd edge. `phy_rst` does not change.
- R11: `done` is a one-cycle pulse. It comes after edge 3+90*`CYC_PER_US` on power-on and after the 2nd edge on power-off, and `req_ready` returns on the edge after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_id | input | 2 | Instance: 0 device, 1 host, 2 HSIC0, 3 HSIC1 |
| req_on | input | 1 | 1 power on, 0 power off |
| req_mhz | input | MHZ_W (8) | Reference clock rate in MHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse for an unsupported rate |
| clk_sel | output | 2 | Reference clock select code |
| pwr_down | output | 13 | Power-down bits, 1 = powered down |
| phy_rst | output | 10 | PHY and link reset bits, 1 = in reset |
| iso_n | output | 2 | Isolation release, bit 0 device, bit 1 host |
| float_prev | output | 1 | Host port floating-prevention control |

## Verification
All results are due at fixed offsets from the edge that accepts a request. The offsets are:

- Power-on: `err` right after the acceptance edge, `clk_sel` after edge 1, power after edge 2, and reset rise after edge 3. Reset fall comes after edge 3+10C, and the isolation release with `done` after edge 3+90C, where C is `CYC_PER_US`.
- Power-off: isolation after edge 1, and power with `done` after edge 2.

For each request, the driver pushes every expected value with its due cycle into a queue. A monitor samples the outputs on the falling edge and compares each entry in the exact cycle it is due. Each change is also checked one cycle before it is due, so it can be neither early nor late. A second request is injected during a busy sequence, and every output is held to its unchanged value.

// File: rtl/usb_pseq_pkg.sv
package usb_pseq_pkg;
  localparam int NUM_PHY = 4;
  localparam int ID_W    = 2;
  localparam int PWR_W   = 13;
  localparam int RST_W   = 10;
  localparam int NUM_ISO = 2;
  localparam int SEL_W   = 2;

  typedef logic [ID_W-1:0] phy_id_t;
  localparam phy_id_t ID_DEV  = 2'd0;
  localparam phy_id_t ID_HOST = 2'd1;
  localparam phy_id_t ID_HS0  = 2'd2;
  localparam phy_id_t ID_HS1  = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BAD, ST_CLK, ST_PWR, ST_RST, ST_HOLD,
    ST_SETTLE, ST_ISO_OFF, ST_DOWN, ST_FIN
  } seq_state_t;

  function automatic logic [PWR_W-1:0] pwr_mask(phy_id_t id);
    logic [PWR_W-1:0] m;
    m = '0;
    case (id)
      ID_DEV:  begin m[0] = 1'b1; m[3] = 1'b1; m[4] = 1'b1; m[5] = 1'b1; end
      ID_HOST: begin m[6] = 1'b1; m[7] = 1'b1; m[8] = 1'b1; end
      ID_HS0:  begin m[9] = 1'b1; m[10] = 1'b1; end
      default: begin m[11] = 1'b1; m[12] = 1'b1; end
    endcase
    return m;
  endfunction

  function automatic logic [RST_W-1:0] rst_mask(phy_id_t id);
    logic [RST_W-1:0] m;
    m = '0;
    case (id)
      ID_DEV:  m[0] = 1'b1;
      ID_HOST: m[7:3] = 5'b11111;
      ID_HS0:  begin m[5] = 1'b1; m[8] = 1'b1; end
      default: begin m[5] = 1'b1; m[9] = 1'b1; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pseq_rate_dec.sv
module pseq_rate_dec #(
  parameter int MHZ_W = 8
) (
  input  logic [MHZ_W-1:0]                   mhz,
  output logic [usb_pseq_pkg::SEL_W-1:0]     code,
  output logic                               ok
);
  always_comb begin
    ok   = 1'b1;
    code = '0;
    case (mhz)
      MHZ_W'(48): code = 2'd0;
      MHZ_W'(24): code = 2'd3;
      MHZ_W'(12): code = 2'd2;
      default:    ok   = 1'b0;
    endcase
  end
endmodule

// File: rtl/pseq_us_timer.sv
module pseq_us_timer #(
  parameter int CYC_PER_US = 250,
  parameter int MAX_US     = 80,
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1,
  localparam int UW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [UW-1:0] load_us,
  output logic          expire
);
  logic [PW-1:0] pre;
  logic [UW-1:0] us_left;
  logic          running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      us_left <= '0;
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      pre     <= PW'(CYC_PER_US - 1);
      us_left <= load_us;
    end else if (running) begin
      if (pre == '0) begin
        pre     <= PW'(CYC_PER_US - 1);
        us_left <= us_left - 1'b1;
        if (us_left == UW'(1)) running <= 1'b0;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign expire = running && (pre == '0) && (us_left == UW'(1));

  // R7
  tmr_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !expire);
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import usb_pseq_pkg::*;
#(
  parameter int HOLD_US   = 10,
  parameter int SETTLE_US = 80,
  parameter int UW        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  phy_id_t           req_id,
  input  logic              req_on,
  input  logic              rate_ok,
  input  logic [SEL_W-1:0]  rate_code,
  input  logic              expire,
  output logic              start,
  output logic [UW-1:0]     load_us,
  output logic              idle,
  output logic              done,
  output logic              err,
  output logic [SEL_W-1:0]  clk_sel,
  output logic [PWR_W-1:0]  pwr_down,
  output logic [RST_W-1:0]  phy_rst,
  output logic [NUM_ISO-1:0] iso_n,
  output logic              float_prev
);
  seq_state_t        state;
  phy_id_t           cur_id;
  logic [SEL_W-1:0]  cur_code;
  logic [PWR_W-1:0]  pm;
  logic [RST_W-1:0]  rm;
  logic              is_host;

  assign pm      = pwr_mask(cur_id);
  assign rm      = rst_mask(cur_id);
  assign is_host = (cur_id == ID_HOST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_id     <= ID_DEV;
      cur_code   <= '0;
      clk_sel    <= '0;
      pwr_down   <= '1;
      phy_rst    <= '0;
      float_prev <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acc) begin
          cur_id   <= req_id;
          cur_code <= rate_code;
          if (!req_on)      state <= ST_ISO_OFF;
          else if (rate_ok) state <= ST_CLK;
          else              state <= ST_BAD;
        end
        ST_BAD: state <= ST_IDLE;
        ST_CLK: begin
          clk_sel <= cur_code;
          state   <= ST_PWR;
        end
        ST_PWR: begin
          pwr_down <= pwr_down & ~pm;
          if (is_host) float_prev <= 1'b1;
          state <= ST_RST;
        end
        ST_RST: begin
          phy_rst <= phy_rst | rm;
          state   <= ST_HOLD;
        end
        ST_HOLD: if (expire) begin
          phy_rst <= phy_rst & ~rm;
          state   <= ST_SETTLE;
        end
        ST_SETTLE: if (expire) state <= ST_FIN;
        ST_ISO_OFF: state <= ST_DOWN;
        ST_DOWN: begin
          pwr_down <= pwr_down | pm;
          if (is_host) float_prev <= 1'b0;
          state <= ST_FIN;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ISO; g++) begin : g_iso
    logic mine;
    logic iso_bit;
    assign mine = (cur_id == phy_id_t'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   iso_bit <= 1'b0;
      else if (mine && state == ST_SETTLE && expire) iso_bit <= 1'b1;
      else if (mine && state == ST_ISO_OFF)          iso_bit <= 1'b0;
    end
    assign iso_n[g] = iso_bit;

    // R8
    iso_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iso_bit |-> ((pwr_down & pwr_mask(phy_id_t'(g))) == '0));
    // R7
    iso_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_bit) |-> ((phy_rst & rst_mask(phy_id_t'(g))) == '0));
  end

  assign start   = (state == ST_RST) || (state == ST_HOLD && expire);
  assign load_us = (state == ST_RST) ? UW'(HOLD_US) : UW'(SETTLE_US);
  assign idle    = (state == ST_IDLE);
  assign done    = (state == ST_FIN);
  assign err     = (state == ST_BAD);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(pwr_down) && $stable(phy_rst) && $stable(clk_sel)
             && $stable(iso_n)));
  // R9
  flt_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    float_prev |-> ((pwr_down & pwr_mask(ID_HOST)) == '0));
  // R11
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle && !done));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !start && !expire && !$past(acc) && state != ST_FIN
     && state != ST_BAD && state != ST_CLK && state != ST_PWR
     && state != ST_ISO_OFF && state != ST_DOWN)
    |=> $stable(pwr_down));
endmodule

// File: rtl/usb_phy_pwr_seq.sv
module usb_phy_pwr_seq #(
  parameter int CYC_PER_US = 250,
  parameter int HOLD_US    = 10,
  parameter int SETTLE_US  = 80,
  parameter int MHZ_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_id,
  input  logic             req_on,
  input  logic [MHZ_W-1:0] req_mhz,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       clk_sel,
  output logic [12:0]      pwr_down,
  output logic [9:0]       phy_rst,
  output logic [1:0]       iso_n,
  output logic             float_prev
);
  localparam int MAX_US = (HOLD_US > SETTLE_US) ? HOLD_US : SETTLE_US;
  localparam int UW     = $clog2(MAX_US + 1);

  logic          acc, idle, rate_ok, start, expire;
  logic [1:0]    rate_code;
  logic [UW-1:0] load_us;

  assign acc       = req_valid && idle;
  assign req_ready = idle;
  assign busy      = !idle;

  pseq_rate_dec #(.MHZ_W(MHZ_W)) u_dec (
    .mhz(req_mhz), .code(rate_code), .ok(rate_ok)
  );

  pseq_us_timer #(.CYC_PER_US(CYC_PER_US), .MAX_US(MAX_US)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .load_us(load_us), .expire(expire)
  );

  pseq_ctrl #(.HOLD_US(HOLD_US), .SETTLE_US(SETTLE_US), .UW(UW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .req_id(req_id), .req_on(req_on),
    .rate_ok(rate_ok), .rate_code(rate_code), .expire(expire),
    .start(start), .load_us(load_us), .idle(idle), .done(done), .err(err),
    .clk_sel(clk_sel), .pwr_down(pwr_down), .phy_rst(phy_rst),
    .iso_n(iso_n), .float_prev(float_prev)
  );
endmodule

// File: tb/sim_usb_phy_pwr_seq.sv
`timescale 1ns/1ps
module sim_usb_phy_pwr_seq;
  localparam int C = 3;
  localparam int K_CLK = 0, K_PWR = 1, K_RST = 2, K_ISO = 3, K_FLT = 4,
                 K_DONE = 5, K_ERR = 6, K_RDY = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_on = 1'b0;
  logic [1:0] req_id = '0;
  logic [7:0] req_mhz = '0;
  logic req_ready, busy, done, err, float_prev;
  logic [1:0] clk_sel, iso_n;
  logic [12:0] pwr_down;
  logic [9:0] phy_rst;

  always #2 clk = ~clk;

  usb_phy_pwr_seq #(.CYC_PER_US(C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_on(req_on), .req_mhz(req_mhz), .busy(busy),
    .done(done), .err(err), .clk_sel(clk_sel), .pwr_down(pwr_down),
    .phy_rst(phy_rst), .iso_n(iso_n), .float_prev(float_prev)
  );

  typedef struct { int due; int kind; logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [12:0] m_pwr = '1;
  logic [1:0]  m_iso = '0, m_clk = '0;
  logic        m_flt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] sample(int k);
    case (k)
      K_CLK:  return 32'(clk_sel);
      K_PWR:  return 32'(pwr_down);
      K_RST:  return 32'(phy_rst);
      K_ISO:  return 32'(iso_n);
      K_FLT:  return 32'(float_prev);
      K_DONE: return 32'(done);
      K_ERR:  return 32'(err);
      default: return 32'(req_ready);
    endcase
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = sample(it.kind);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s (kind %0d, cycle %0d): actual %0h expected %0h",
                 it.tag, it.kind, cyc, act, it.exp);
      end
    end
  end

  task automatic push(int due, int kind, logic [31:0] v, string tag);
    exp_t it;
    it.due = due; it.kind = kind; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  function automatic logic [12:0] pmask(int id);
    case (id)
      0: return 13'b0_0000_0011_1001;
      1: return 13'b0_0001_1100_0000;
      2: return 13'b0_0110_0000_0000;
      default: return 13'b1_1000_0000_0000;
    endcase
  endfunction

  function automatic logic [9:0] rmask(int id);
    case (id)
      0: return 10'b00_0000_0001;
      1: return 10'b00_1111_1000;
      2: return 10'b01_0010_0000;
      default: return 10'b10_0010_0000;
    endcase
  endfunction

  function automatic int code_of(int mhz);
    case (mhz)
      48: return 0;
      24: return 3;
      12: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic request(int id, bit on, int mhz, bit intrude);
    int a, code, fin;
    logic [12:0] np;
    logic [1:0]  ni;
    logic        nf;
    @(negedge clk);
    a = cyc;
    req_valid = 1; req_id = 2'(id); req_on = on; req_mhz = 8'(mhz);
    code = code_of(mhz);
    np = m_pwr; ni = m_iso; nf = m_flt;
    push(a + 1, K_RDY, 0, "R2 ready drops");
    if (on && code < 0) begin
      push(a + 1, K_ERR, 1, "R4 err pulse");
      push(a + 2, K_ERR, 0, "R4 err one cycle");
      push(a + 2, K_DONE, 0, "R4 no done");
      push(a + 2, K_PWR, 32'(m_pwr), "R4 pwr unchanged");
      push(a + 2, K_CLK, 32'(m_clk), "R4 clk unchanged");
      push(a + 2, K_ISO, 32'(m_iso), "R4 iso unchanged");
      push(a + 2, K_RST, 0, "R4 rst unchanged");
      push(a + 2, K_RDY, 1, "R2 ready back");
      fin = a + 3;
    end else if (on) begin
      np = m_pwr & ~pmask(id);
      if (id < 2) ni[id] = 1'b1;
      if (id == 1) nf = 1'b1;
      push(a + 1, K_ERR, 0, "R4 no err");
      push(a + 2, K_CLK, 32'(code), "R3 clock code");
      push(a + 2, K_PWR, 32'(m_pwr), "R5 pwr not yet");
      push(a + 3, K_PWR, 32'(np), "R5 pwr cleared");
      push(a + 3, K_RST, 0, "R7 rst after pwr");
      push(a + 3, K_FLT, 32'(nf), "R9 float on");
      push(a + 4, K_RST, 32'(rmask(id)), "R6 rst mask");
      if (intrude) begin
        while (cyc < a + 1) @(negedge clk);
        req_valid = 0;
        while (cyc < a + 20) @(negedge clk);
        req_valid = 1; req_on = 0; req_id = 2'(id); req_mhz = 8'd48;
        push(a + 20, K_RDY, 0, "R2 busy ignores");
        @(negedge clk);
        req_valid = 0;
      end
      push(a + 3 + 10*C, K_RST, 32'(rmask(id)), "R7 rst still held");
      push(a + 4 + 10*C, K_RST, 0, "R7 rst released");
      push(a + 3 + 90*C, K_ISO, 32'(m_iso), "R8 iso still held");
      push(a + 3 + 90*C, K_DONE, 0, "R11 done not early");
      push(a + 4 + 90*C, K_ISO, 32'(ni), "R8 iso released");
      push(a + 4 + 90*C, K_DONE, 1, "R11 done pulse");
      push(a + 4 + 90*C, K_PWR, 32'(np), "R2 pwr final");
      push(a + 5 + 90*C, K_DONE, 0, "R11 done one cycle");
      push(a + 5 + 90*C, K_RDY, 1, "R11 ready after done");
      m_clk = 2'(code);
      fin = a + 6 + 90*C;
    end else begin
      np = m_pwr | pmask(id);
      if (id < 2) ni[id] = 1'b0;
      if (id == 1) nf = 1'b0;
      push(a + 1, K_ERR, 0, "R4 off ignores rate");
      push(a + 2, K_ISO, 32'(ni), "R10 iso first");
      push(a + 2, K_PWR, 32'(m_pwr), "R10 pwr after iso");
      push(a + 2, K_RST, 0, "R10 no reset");
      push(a + 3, K_PWR, 32'(np), "R5 pwr set");
      push(a + 3, K_FLT, 32'(nf), "R9 float off");
      push(a + 3, K_DONE, 1, "R11 off done");
      push(a + 3, K_CLK, 32'(m_clk), "R10 clk kept");
      push(a + 4, K_DONE, 0, "R11 off done one cycle");
      push(a + 4, K_RDY, 1, "R2 ready after off");
      fin = a + 5;
    end
    m_pwr = np; m_iso = ni; m_flt = nf;
    while (cyc < a + 1) @(negedge clk);
    req_valid = 0;
    while (cyc < fin) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    push(cyc + 1, K_PWR, 32'h1fff, "R1 pwr reset");
    push(cyc + 1, K_RST, 0, "R1 rst reset");
    push(cyc + 1, K_ISO, 0, "R1 iso reset");
    push(cyc + 1, K_FLT, 0, "R1 float reset");
    push(cyc + 1, K_CLK, 0, "R1 clk reset");
    push(cyc + 1, K_RDY, 1, "R1 ready reset");
    push(cyc + 1, K_DONE, 0, "R1 done reset");
    push(cyc + 1, K_ERR, 0, "R1 err reset");
    repeat (2) @(negedge clk);
    request(0, 1, 48, 1);
    request(1, 1, 12, 0);
    request(2, 1, 24, 0);
    request(3, 1, 24, 0);
    request(1, 1, 100, 0);
    request(3, 1, 25, 0);
    request(2, 0, 25, 0);
    request(0, 0, 48, 0);
    request(1, 0, 12, 0);
    request(3, 0, 48, 0);
    request(0, 1, 12, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule